// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block supplies operand addresses for memory transfers. It keeps a small bank of pointer registers. Each pointer has its own length register, and there is a bank of modify registers of the same size. An access request names one pointer and, separately, one modify register. On the clock edge that takes the request, the block registers the pointer's present value as the outgoing address. At the same edge it overwrites the pointer with that value plus the signed modify amount. So every indirect access post-increments or post-decrements its pointer with no extra cycle.

When a pointer's length is nonzero, the pointer walks a circular buffer. The buffer starts at the pointer value with its low bits cleared, down to the smallest power of two that is not below the length. A step that leaves the buffer is folded back by the length. A mode input can mirror the outgoing address bit for bit, which serves radix-2 FFT data reordering. The mirroring is built only when the `HAS_BITREV` parameter is set. A processor can therefore place two instances side by side, one with the mirror and one without, to get two addresses in the same cycle. All register loads go through one write port, selected by a kind code and an index.

Top module: `agen_circ`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pointer, modify and length registers clear to zero, and `addr_valid` and `addr` go to zero one cycle later.
- R2: A write with `wr_en` high loads `wr_data` into the register named by `wr_idx` and `wr_kind`. The kind codes are 2'b00 for pointer, 2'b01 for modify and 2'b10 for length. Code 2'b11 changes no register. The new value is used by accesses from the next cycle on.
- R3: One cycle after an edge that samples `acc_valid` high, `addr_valid` is high and `addr` holds the selected pointer's value from before its update. `addr_valid` is low one cycle after an edge with `acc_valid` low.
- R4: An access replaces the pointer chosen by `acc_ptr_sel` with its old value plus the contents of the modify register chosen by `acc_mod_sel`. That modify value is read as 14-bit two's complement, and the choice of modify register does not depend on the pointer.
- R5: With the selected pointer's length at zero, the update is plain addition modulo 2^14. For example, 0x3FFE plus 5 gives 0x0003.
- R6: With length L nonzero, the buffer base B is the pointer with its low k bits cleared, where 2^k is the smallest power of two with 2^k >= L. If a non-negative modify takes the sum above B+L-1, L is subtracted. This assumes the modify magnitude is at most L.
- R7: With length L nonzero and a negative modify, a sum below B has L added, so the pointer reappears at the top of its buffer.
- R8: When `HAS_BITREV`=1 and `bitrev_mode` is high with the request, bit i of `addr` equals bit 13-i of the pointer value. The stored pointer still updates in normal bit order.
- R9: When `HAS_BITREV`=0, `bitrev_mode` has no effect on `addr`.
- R10: If a pointer write and an access target the same pointer in one cycle, the pointer ends up holding `wr_data`, while `addr` still shows the old pointer value.
- R11: An access leaves every pointer other than the selected one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 00 pointer, 01 modify, 10 length, 11 none |
| wr_idx | input | 2 | Register index within its kind |
| wr_data | input | 14 | Register write value |
| acc_valid | input | 1 | Access request |
| acc_ptr_sel | input | 2 | Pointer used by the access |
| acc_mod_sel | input | 2 | Modify register used by the access |
| bitrev_mode | input | 1 | Mirror the outgoing address |
| addr_valid | output | 1 | Address output holds a new address |
| addr | output | 14 | Generated address |

## Verification
The bench drives pointers across the top of the address space. A design that let the carry reach the wrap logic, or that sign-extended badly, would return a large value instead of 0x0003. Circular buffers are walked forward past the top and backward past the base, with non-power-of-two lengths. An off-by-one limit would show up as an address outside the buffer or one slot late. The bench also accesses a pointer immediately after a mirrored access. A design that stored the mirrored value would corrupt that pointer, and one that reversed only part of the word would give a wrong mirror. Finally, the bench writes and accesses the same pointer in one cycle, and it also issues writes with the unused kind code. In both cases a later access shows whether the write priority or the ignored code was handled correctly.

// File: rtl/agen_pkg.sv
// Shared definitions for the circular-buffer address generator.
package agen_pkg;
    // Kind code of the single register write port.
    typedef enum logic [1:0] {
        WK_PTR  = 2'b00,
        WK_MOD  = 2'b01,
        WK_LEN  = 2'b10,
        WK_NONE = 2'b11
    } wr_kind_e;
endpackage

// File: rtl/agen_regs.sv
// Register bank: NREG pointers, NREG modify values, NREG lengths.
// Assumes one write per cycle. A pointer write wins over an access update
// to the same pointer in the same cycle. Reads are combinational.
module agen_regs
    import agen_pkg::*;
#(
    parameter int AW   = 14,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [SELW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [SELW-1:0] upd_idx,
    input  logic [AW-1:0]   upd_data,
    input  logic [SELW-1:0] rd_ptr_idx,
    input  logic [SELW-1:0] rd_mod_idx,
    output logic [AW-1:0]   rd_ptr,
    output logic [AW-1:0]   rd_len,
    output logic [AW-1:0]   rd_mod
);
    logic [AW-1:0] ptr_r [NREG];
    logic [AW-1:0] mod_r [NREG];
    logic [AW-1:0] len_r [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit_ptr, hit_mod, hit_len, hit_upd;
        assign hit_ptr = wr_en && (wr_kind == WK_PTR) && (wr_idx == SELW'(i));
        assign hit_mod = wr_en && (wr_kind == WK_MOD) && (wr_idx == SELW'(i));
        assign hit_len = wr_en && (wr_kind == WK_LEN) && (wr_idx == SELW'(i));
        assign hit_upd = upd_en && (upd_idx == SELW'(i));

        // Pointer: reset, then software write, then access update.
        always_ff @(posedge clk) begin
            if (!rst_n)       ptr_r[i] <= '0;
            else if (hit_ptr) ptr_r[i] <= wr_data;
            else if (hit_upd) ptr_r[i] <= upd_data;
        end

        // Modify and length registers: loaded only by writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_r[i] <= '0;
                len_r[i] <= '0;
            end else begin
                if (hit_mod) mod_r[i] <= wr_data;
                if (hit_len) len_r[i] <= wr_data;
            end
        end
    end

    // Read ports for the access in flight.
    always_comb begin
        rd_ptr = ptr_r[rd_ptr_idx];
        rd_len = len_r[rd_ptr_idx];
        rd_mod = mod_r[rd_mod_idx];
    end
endmodule

// File: rtl/agen_wrap.sv
// Next-pointer arithmetic: signed post-modify with optional circular wrap.
// Assumes |modify| <= length when length is nonzero (one fold suffices).
module agen_wrap #(
    parameter int AW = 14,
    localparam int XW = AW + 2
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0]        mask;
    logic [AW-1:0]        base;
    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] lo;
    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] lenx;
    logic signed [XW-1:0] fixed;

    // Buffer size mask: smear the top set bit of (len-1) downward.
    always_comb begin
        mask = len - AW'(1);
        for (int s = 1; s < AW; s = s * 2) begin
            mask = mask | (mask >> s);
        end
        base = ptr & ~mask;
    end

    // Widened sum and limits so that no carry is lost before comparing.
    always_comb begin
        sum   = $signed({2'b00, ptr}) + $signed({{2{modv[AW-1]}}, modv});
        lenx  = $signed({2'b00, len});
        lo    = $signed({2'b00, base});
        hi    = lo + lenx - XW'(1);
        fixed = sum;
        if (len != '0) begin
            if (!modv[AW-1] && (sum > hi))     fixed = sum - lenx;
            else if (modv[AW-1] && (sum < lo)) fixed = sum + lenx;
        end
        nxt = fixed[AW-1:0];
    end
endmodule

// File: rtl/agen_bitrev.sv
// Output address formatter: mirrors all AW bits when ENABLE=1 and mode is
// high, otherwise passes the address through unchanged.
module agen_bitrev #(
    parameter int AW     = 14,
    parameter bit ENABLE = 1'b1
) (
    input  logic          mode,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    if (ENABLE) begin : g_rev
        logic [AW-1:0] mirrored;
        for (genvar i = 0; i < AW; i++) begin : g_bit
            assign mirrored[i] = din[AW-1-i];
        end
        // Select mirrored or straight order.
        assign dout = mode ? mirrored : din;
    end else begin : g_pass
        logic unused_mode;
        assign unused_mode = mode;
        assign dout = din;
    end
endmodule

// File: rtl/agen_circ.sv
// Address generator top: register bank, next-pointer arithmetic and
// output formatter. One access per cycle; address is registered, so it
// appears one cycle after the request. Synchronous active-low reset.
module agen_circ
    import agen_pkg::*;
#(
    parameter int AW         = 14,
    parameter int NREG       = 4,
    parameter bit HAS_BITREV = 1'b1,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [SELW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            acc_valid,
    input  logic [SELW-1:0] acc_ptr_sel,
    input  logic [SELW-1:0] acc_mod_sel,
    input  logic            bitrev_mode,
    output logic            addr_valid,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] sel_ptr;
    logic [AW-1:0] sel_len;
    logic [AW-1:0] sel_mod;
    logic [AW-1:0] next_ptr;
    logic [AW-1:0] fmt_addr;
    logic          valid_q;
    logic [AW-1:0] addr_q;

    agen_regs #(.AW(AW), .NREG(NREG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .upd_en     (acc_valid),
        .upd_idx    (acc_ptr_sel),
        .upd_data   (next_ptr),
        .rd_ptr_idx (acc_ptr_sel),
        .rd_mod_idx (acc_mod_sel),
        .rd_ptr     (sel_ptr),
        .rd_len     (sel_len),
        .rd_mod     (sel_mod)
    );

    agen_wrap #(.AW(AW)) u_wrap (
        .ptr  (sel_ptr),
        .modv (sel_mod),
        .len  (sel_len),
        .nxt  (next_ptr)
    );

    agen_bitrev #(.AW(AW), .ENABLE(HAS_BITREV)) u_fmt (
        .mode (bitrev_mode),
        .din  (sel_ptr),
        .dout (fmt_addr)
    );

    // Output register: pre-update pointer, optionally mirrored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= acc_valid;
            if (acc_valid) addr_q <= fmt_addr;
        end
    end

    assign addr_valid = valid_q;
    assign addr       = addr_q;
endmodule

// File: rtl/agen_circ_chk.sv
// Assertion checker for agen_circ, attached with bind. Recomputes the
// mirror and the buffer limits on its own.
module agen_circ_chk #(
    parameter int AW         = 14,
    parameter bit HAS_BITREV = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          bitrev_mode,
    input logic          addr_valid,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] sel_ptr,
    input logic [AW-1:0] sel_mod,
    input logic [AW-1:0] sel_len,
    input logic [AW-1:0] next_ptr
);
    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    function automatic logic [AW:0] buf_base(input logic [AW-1:0] p, input logic [AW-1:0] l);
        logic [AW:0] sz;
        sz = (AW+1)'(1);
        for (int k = 0; k < AW; k++) if (sz < {1'b0, l}) sz = sz << 1;
        return {1'b0, p} - ({1'b0, p} % sz);
    endfunction

    logic [AW:0] c_base, c_top, c_ptr, c_nxt, c_mag;
    always_comb begin
        c_base = buf_base(sel_ptr, sel_len);
        c_top  = c_base + {1'b0, sel_len} - (AW+1)'(1);
        c_ptr  = {1'b0, sel_ptr};
        c_nxt  = {1'b0, next_ptr};
        c_mag  = sel_mod[AW-1] ? {1'b0, -sel_mod} : {1'b0, sel_mod};
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && addr == '0));

    p_valid_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> addr_valid);

    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !addr_valid);

    p_old_ptr_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(HAS_BITREV && bitrev_mode)) |=> addr == $past(sel_ptr));

    p_mirror_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && HAS_BITREV && bitrev_mode) |=> addr == mirror($past(sel_ptr)));

    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sel_len == '0) |-> next_ptr == AW'(sel_ptr + sel_mod));

    p_stay_in_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sel_len != '0 && c_ptr <= c_top && c_mag <= {1'b0, sel_len})
        |-> (c_nxt >= c_base && c_nxt <= c_top));
endmodule

bind agen_circ agen_circ_chk #(.AW(AW), .HAS_BITREV(HAS_BITREV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .bitrev_mode (bitrev_mode),
    .addr_valid  (addr_valid),
    .addr        (addr),
    .sel_ptr     (sel_ptr),
    .sel_mod     (sel_mod),
    .sel_len     (sel_len),
    .next_ptr    (next_ptr)
);

// File: tb/agen_circ_test.sv
// Scoreboard bench: the driver task predicts addresses from its own model
// and queues them; the monitor compares on each valid output.
module agen_circ_test;
    localparam int AW = 14;

    typedef struct {
        logic [AW-1:0] exp_a;
        logic [AW-1:0] exp_b;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'b00;
    logic [1:0]    wr_idx = 2'b00;
    logic [AW-1:0] wr_data = '0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_ptr_sel = 2'b00;
    logic [1:0]    acc_mod_sel = 2'b00;
    logic          bitrev_mode = 1'b0;
    logic          va, vb;
    logic [AW-1:0] aa, ab;

    int total = 0;
    int bad = 0;
    bit done = 0;
    item_t q[$];

    int m_ptr[4];
    int m_mod[4];
    int m_len[4];

    always #2 clk = ~clk;

    agen_circ #(.HAS_BITREV(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .acc_valid(acc_valid),
        .acc_ptr_sel(acc_ptr_sel), .acc_mod_sel(acc_mod_sel),
        .bitrev_mode(bitrev_mode), .addr_valid(va), .addr(aa));

    agen_circ #(.HAS_BITREV(1'b0)) uut_nb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .acc_valid(acc_valid),
        .acc_ptr_sel(acc_ptr_sel), .acc_mod_sel(acc_mod_sel),
        .bitrev_mode(bitrev_mode), .addr_valid(vb), .addr(ab));

    function automatic int model_next(int p, int m, int l);
        int sm, p2, base, s;
        sm = (m >= 8192) ? m - 16384 : m;
        if (l == 0) return (p + sm) & 16383;
        p2 = 1;
        while (p2 < l) p2 = p2 * 2;
        base = p - (p % p2);
        s = p + sm;
        if (sm >= 0 && s > base + l - 1) s = s - l;
        else if (sm < 0 && s < base) s = s + l;
        return s & 16383;
    endfunction

    function automatic logic [AW-1:0] model_rev(logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[AW-1-i] = v[i];
        return r;
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus with optional write and optional access.
    task automatic step(bit we, logic [1:0] kind, int idx, int data,
                        bit acc, int ps, int ms, bit br, string tag);
        item_t it;
        int old;
        @(negedge clk);
        wr_en = we; wr_kind = kind; wr_idx = 2'(idx); wr_data = AW'(data);
        acc_valid = acc; acc_ptr_sel = 2'(ps); acc_mod_sel = 2'(ms); bitrev_mode = br;
        if (acc) begin
            old = m_ptr[ps];
            it.exp_a = br ? model_rev(AW'(old)) : AW'(old);
            it.exp_b = AW'(old);
            it.tag = tag;
            q.push_back(it);
            m_ptr[ps] = model_next(old, m_mod[ms], m_len[ps]);
        end
        if (we) begin
            case (kind)
                2'b00: m_ptr[idx] = data;
                2'b01: m_mod[idx] = data;
                2'b10: m_len[idx] = data;
                default: ;
            endcase
        end
    endtask

    task automatic wr(logic [1:0] kind, int idx, int data);
        step(1, kind, idx, data, 0, 0, 0, 0, "R2");
    endtask

    task automatic acc(int ps, int ms, bit br, string tag);
        step(0, 2'b00, 0, 0, 1, ps, ms, br, tag);
    endtask

    task automatic idle();
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare each valid output against the queue head.
    always @(negedge clk) begin
        if (rst_n && (va || vb)) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 actual=valid expected=no pending access");
            end else begin
                item_t it;
                it = q.pop_front();
                check({it.tag, " main"}, aa, it.exp_a);
                check({it.tag, " nobitrev"}, ab, it.exp_b);
                total++;
                if (va !== vb) begin
                    bad++;
                    $display("FAIL R3 actual=%b expected=%b", vb, va);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_mod[i] = 0; m_len[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 addr", aa, '0);
        check("R1 valid", AW'(va), '0);
        rst_n = 1'b1;
        acc(0, 0, 0, "R1");                 // pointer reset to zero
        // R2, R3, R4: linear walk of pointer 0 with modify 1 = 3
        wr(2'b00, 0, 14'h0100);
        wr(2'b01, 1, 3);
        acc(0, 1, 0, "R3");
        acc(0, 1, 0, "R4");
        acc(0, 1, 0, "R4");
        idle();
        @(negedge clk);
        check("R3 idle", AW'(va), '0);
        // R5: linear wrap at the top of the space
        wr(2'b00, 1, 14'h3FFE);
        wr(2'b01, 2, 5);
        acc(1, 2, 0, "R5");
        acc(1, 2, 0, "R5");
        // R6: forward circular walk, L=10, base 0x40
        wr(2'b00, 2, 14'h0040);
        wr(2'b10, 2, 10);
        for (int k = 0; k < 8; k++) acc(2, 1, 0, "R6");
        // R7: backward circular walk, L=6, base 0x80, modify -3
        wr(2'b00, 3, 14'h0082);
        wr(2'b10, 3, 6);
        wr(2'b01, 3, 14'h3FFD);
        for (int k = 0; k < 6; k++) acc(3, 3, 0, "R7");
        // R8, R9: mirrored access then normal access of the same pointer
        wr(2'b00, 0, 14'h0005);
        wr(2'b01, 0, 1);
        acc(0, 0, 1, "R8");
        acc(0, 0, 0, "R8");
        acc(0, 0, 1, "R9");
        // R11: other pointers untouched by the accesses above
        acc(1, 0, 0, "R11");
        acc(2, 0, 0, "R11");
        // R10: same-cycle pointer write and access
        step(1, 2'b00, 3, 14'h1234, 1, 3, 0, 0, "R10");
        acc(3, 0, 0, "R10");
        // R2: kind code 11 changes nothing
        step(1, 2'b11, 0, 14'h2AAA, 0, 0, 0, 0, "R2");
        step(1, 2'b11, 1, 14'h2AAA, 0, 0, 0, 0, "R2");
        acc(0, 0, 0, "R2");
        acc(1, 2, 0, "R2");
        idle();
        idle();
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R3 actual=%0d expected=0 pending", q.size());
        end
        finish_run();
    end
endmodule